// File: doc/BRIEF.md
# Read-Protection Level Option Manager

This block owns the protection option state of an on-chip flash controller: an 8-bit protection byte, a per-sector mask and a mode bit that selects what the mask means. Software first opens the option path with a two-word key sequence. It then presents the requested option values together with a start strobe. The block judges the request against the current state and reacts in one of three ways. It refuses the request and raises a write-protect error. It accepts the request and runs a plain option rewrite. Or it accepts the request and runs a mass erase of the user sectors ahead of the option rewrite.

The protection level is decoded from the protection byte. Two byte values are reserved: one for the open level 0 and one for the permanent level 2. Every other value means level 1. Going from level 1 to level 0 is the only downward move, and it always costs a mass erase. Level 2 can never be left. When the mode bit is set, the sector mask marks sectors that reject data-port reads. Instruction fetches to those sectors are still served. The block flags any data-port read to such a sector with a one-cycle read error.

Top module: `opt_level_mgr`

## Requirements
- R1: After reset the protection byte is 0xAA, the sector mask is all ones, the mode bit is 0, the path is locked, and busy, mass-erase, done and both error outputs are low.
- R2: The path unlocks only when the key register receives 0x08192A3B and then 0x4C5D6E7F. A wrong word at either step, or any key write while unlocked, keeps the path locked until reset. A relock pulse while unlocked returns it to the locked state, where the key sequence works again.
- R3: prot_level is 0 when the protection byte is 0xAA, 2 when it is 0xCC, and 1 for every other value. It never takes the value 3.
- R4: A start strobe has no effect while the path is locked or while an update is running.
- R5: An accepted update holds busy high for exactly OBER_CYC+OBPG_CYC cycles, plus MASS_CYC cycles when it erases. Outputs keep their old option values until busy falls. Busy falls in the cycle in which the requested byte, mask and mode appear, and upd_done pulses for that one cycle.
- R6: An accepted request that moves the level from 1 to 0 raises mass_erase_act for exactly MASS_CYC cycles, inside the busy window.
- R7: An accepted request that raises the level or keeps it the same never erases, including a request with no net change.
- R8: A request that would leave level 2 is refused. wrp_err pulses for one cycle, busy stays low, and the option state is unchanged.
- R9: While the old mode bit is 1, a request that clears the mode bit, or clears any mask bit, is accepted only when it also moves the level from 1 to 0. Otherwise it is refused as in R8.
- R10: sect_rdprot equals the sector mask when the mode bit is 1, and is all zeros when the mode bit is 0.
- R11: A read with rd_dport=1 to a sector whose sect_rdprot bit is 1 pulses rd_err in the cycle after the request. Reads with rd_dport=0, reads to unprotected sectors, and reads to sector numbers at or above NSECT give no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_we | input | 1 | Key register write strobe |
| key_wdata | input | 32 | Key word |
| relock | input | 1 | Relock the option path |
| start | input | 1 | Start an option update |
| req_rdp | input | 8 | Requested protection byte |
| req_mask | input | NSECT | Requested sector mask |
| req_mode | input | 1 | Requested mode bit |
| rd_req | input | 1 | Flash read request |
| rd_dport | input | 1 | 1 = data-port read, 0 = instruction fetch |
| rd_sector | input | SECW | Sector of the read |
| opt_unlocked | output | 1 | Option path open |
| opt_busy | output | 1 | Update in progress |
| mass_erase_act | output | 1 | User-sector mass erase in progress |
| upd_done | output | 1 | One-cycle pulse when an update completes |
| wrp_err | output | 1 | One-cycle pulse when a request is refused |
| rd_err | output | 1 | One-cycle pulse for a refused data read |
| prot_level | output | 2 | Decoded level (0, 1, 2) |
| rdp_byte | output | 8 | Current protection byte |
| sect_mask | output | NSECT | Current sector mask |
| prot_mode | output | 1 | Current mode bit |
| sect_rdprot | output | NSECT | Per-sector read protection |

## Verification
The bench keeps the default of twelve sectors and shortens the phases to MASS_CYC=3, OBER_CYC=2 and OBPG_CYC=2, so that a full update finishes in a handful of cycles. With phases this short, a fresh reset and setup before every case fits within the run. That makes it possible to sweep every pair of old and new levels (using four protection byte values), every pair of old and new mode bits, and masks with and without a removed sector. It also decodes all 256 protection byte values and probes every sector number, including the out-of-range ones, on both read ports.

// File: rtl/opt_mgr_pkg.sv
package opt_mgr_pkg;

  localparam logic [31:0] OPT_KEY_FIRST  = 32'h0819_2A3B;
  localparam logic [31:0] OPT_KEY_SECOND = 32'h4C5D_6E7F;

  localparam logic [7:0] RDP_OPEN_VAL = 8'hAA;
  localparam logic [7:0] RDP_PERM_VAL = 8'hCC;

  typedef enum logic [1:0] {
    LVL_OPEN = 2'd0,
    LVL_MID  = 2'd1,
    LVL_PERM = 2'd2
  } prot_lvl_e;

  typedef enum logic [1:0] {
    KG_WAIT_A = 2'd0,
    KG_WAIT_B = 2'd1,
    KG_OPEN   = 2'd2,
    KG_DEAD   = 2'd3
  } key_st_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_MASS = 2'd1,
    SQ_OBER = 2'd2,
    SQ_OBPG = 2'd3
  } seq_st_e;

  function automatic prot_lvl_e lvl_of(input logic [7:0] b);
    if (b == RDP_OPEN_VAL)      return LVL_OPEN;
    else if (b == RDP_PERM_VAL) return LVL_PERM;
    else                        return LVL_MID;
  endfunction

endpackage

// File: rtl/opt_key_gate.sv
module opt_key_gate
  import opt_mgr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [31:0] key_wdata,
  input  logic        relock,
  output logic        unlocked
);

  key_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      KG_WAIT_A: if (key_we) st_d = (key_wdata == OPT_KEY_FIRST)  ? KG_WAIT_B : KG_DEAD;
      KG_WAIT_B: if (key_we) st_d = (key_wdata == OPT_KEY_SECOND) ? KG_OPEN   : KG_DEAD;
      KG_OPEN: begin
        if (key_we)      st_d = KG_DEAD;
        else if (relock) st_d = KG_WAIT_A;
      end
      default:           st_d = KG_DEAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KG_WAIT_A;
    else        st_q <= st_d;
  end

  assign unlocked = (st_q == KG_OPEN);

endmodule

// File: rtl/opt_rule_check.sv
module opt_rule_check
  import opt_mgr_pkg::*;
#(
  parameter int NSECT = 12
) (
  input  logic [7:0]       cur_rdp,
  input  logic [NSECT-1:0] cur_mask,
  input  logic             cur_mode,
  input  logic [7:0]       req_rdp,
  input  logic [NSECT-1:0] req_mask,
  input  logic             req_mode,
  output logic             refuse,
  output logic             erase
);

  prot_lvl_e old_lvl, new_lvl;
  logic      leave_perm;
  logic      drop_mode;
  logic      drop_sector;
  logic      open_step;

  always_comb begin
    old_lvl     = lvl_of(cur_rdp);
    new_lvl     = lvl_of(req_rdp);
    leave_perm  = (old_lvl == LVL_PERM) && (new_lvl != LVL_PERM);
    drop_mode   = cur_mode && !req_mode;
    drop_sector = cur_mode && req_mode && (|(cur_mask & ~req_mask));
    open_step   = (old_lvl == LVL_MID) && (new_lvl == LVL_OPEN);
    refuse      = leave_perm || ((drop_mode || drop_sector) && !open_step);
    erase       = !refuse && open_step;
  end

endmodule

// File: rtl/opt_update_seq.sv
module opt_update_seq
  import opt_mgr_pkg::*;
#(
  parameter int NSECT    = 12,
  parameter int MASS_CYC = 16,
  parameter int OBER_CYC = 4,
  parameter int OBPG_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_erase,
  input  logic [7:0]       req_rdp,
  input  logic [NSECT-1:0] req_mask,
  input  logic             req_mode,
  output logic [7:0]       cur_rdp,
  output logic [NSECT-1:0] cur_mask,
  output logic             cur_mode,
  output logic             busy,
  output logic             mass_act,
  output logic             done
);

  localparam int MAXC1 = (MASS_CYC > OBER_CYC) ? MASS_CYC : OBER_CYC;
  localparam int MAXC  = (MAXC1 > OBPG_CYC) ? MAXC1 : OBPG_CYC;
  localparam int CW    = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] MASS_LAST = CW'(MASS_CYC - 1);
  localparam logic [CW-1:0] OBER_LAST = CW'(OBER_CYC - 1);
  localparam logic [CW-1:0] OBPG_LAST = CW'(OBPG_CYC - 1);

  seq_st_e          st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [7:0]       pend_rdp_q;
  logic [NSECT-1:0] pend_mask_q;
  logic             pend_mode_q;
  logic             pend_en;
  logic             commit;
  logic             done_d;

  // next state and phase counter
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    commit = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (go) begin
          st_d  = go_erase ? SQ_MASS : SQ_OBER;
          cnt_d = go_erase ? MASS_LAST : OBER_LAST;
        end
      end
      SQ_MASS: begin
        if (cnt_q == '0) begin
          st_d  = SQ_OBER;
          cnt_d = OBER_LAST;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_OBER: begin
        if (cnt_q == '0) begin
          st_d  = SQ_OBPG;
          cnt_d = OBPG_LAST;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        if (cnt_q == '0) begin
          st_d   = SQ_IDLE;
          cnt_d  = '0;
          commit = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    endcase
    pend_en = go && (st_q == SQ_IDLE);
    done_d  = commit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      done  <= done_d;
    end
  end

  // snapshot of the accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_rdp_q  <= '0;
      pend_mask_q <= '0;
      pend_mode_q <= 1'b0;
    end else if (pend_en) begin
      pend_rdp_q  <= req_rdp;
      pend_mask_q <= req_mask;
      pend_mode_q <= req_mode;
    end
  end

  // live option state, rewritten at the end of the programming phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_rdp  <= RDP_OPEN_VAL;
      cur_mask <= '1;
      cur_mode <= 1'b0;
    end else if (commit) begin
      cur_rdp  <= pend_rdp_q;
      cur_mask <= pend_mask_q;
      cur_mode <= pend_mode_q;
    end
  end

  assign busy     = (st_q != SQ_IDLE);
  assign mass_act = (st_q == SQ_MASS);

endmodule

// File: rtl/opt_level_mgr.sv
module opt_level_mgr
  import opt_mgr_pkg::*;
#(
  parameter int NSECT    = 12,
  parameter int SECW     = $clog2(NSECT),
  parameter int MASS_CYC = 16,
  parameter int OBER_CYC = 4,
  parameter int OBPG_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_we,
  input  logic [31:0]      key_wdata,
  input  logic             relock,
  input  logic             start,
  input  logic [7:0]       req_rdp,
  input  logic [NSECT-1:0] req_mask,
  input  logic             req_mode,
  input  logic             rd_req,
  input  logic             rd_dport,
  input  logic [SECW-1:0]  rd_sector,
  output logic             opt_unlocked,
  output logic             opt_busy,
  output logic             mass_erase_act,
  output logic             upd_done,
  output logic             wrp_err,
  output logic             rd_err,
  output logic [1:0]       prot_level,
  output logic [7:0]       rdp_byte,
  output logic [NSECT-1:0] sect_mask,
  output logic             prot_mode,
  output logic [NSECT-1:0] sect_rdprot
);

  localparam int SPAN = 1 << SECW;

  logic            refuse, erase_need;
  logic            start_ok, go;
  logic            wrp_err_d, rd_err_d;
  logic [SPAN-1:0] prot_ext;

  opt_key_gate u_keys (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_we    (key_we),
    .key_wdata (key_wdata),
    .relock    (relock),
    .unlocked  (opt_unlocked)
  );

  opt_rule_check #(.NSECT(NSECT)) u_rules (
    .cur_rdp  (rdp_byte),
    .cur_mask (sect_mask),
    .cur_mode (prot_mode),
    .req_rdp  (req_rdp),
    .req_mask (req_mask),
    .req_mode (req_mode),
    .refuse   (refuse),
    .erase    (erase_need)
  );

  opt_update_seq #(
    .NSECT    (NSECT),
    .MASS_CYC (MASS_CYC),
    .OBER_CYC (OBER_CYC),
    .OBPG_CYC (OBPG_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .go_erase (erase_need),
    .req_rdp  (req_rdp),
    .req_mask (req_mask),
    .req_mode (req_mode),
    .cur_rdp  (rdp_byte),
    .cur_mask (sect_mask),
    .cur_mode (prot_mode),
    .busy     (opt_busy),
    .mass_act (mass_erase_act),
    .done     (upd_done)
  );

  always_comb begin
    start_ok    = start && opt_unlocked && !opt_busy;
    go          = start_ok && !refuse;
    wrp_err_d   = start_ok && refuse;
    prot_level  = lvl_of(rdp_byte);
    sect_rdprot = prot_mode ? sect_mask : '0;
    prot_ext    = SPAN'(sect_rdprot);
    rd_err_d    = rd_req && rd_dport && prot_ext[rd_sector];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrp_err <= 1'b0;
      rd_err  <= 1'b0;
    end else begin
      wrp_err <= wrp_err_d;
      rd_err  <= rd_err_d;
    end
  end

endmodule

// File: rtl/opt_level_mgr_chk.sv
module opt_level_mgr_chk #(
  parameter int NSECT = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             opt_unlocked,
  input logic             opt_busy,
  input logic             mass_erase_act,
  input logic             upd_done,
  input logic             wrp_err,
  input logic [1:0]       prot_level,
  input logic [7:0]       rdp_byte,
  input logic             prot_mode,
  input logic [NSECT-1:0] sect_rdprot
);

  // R3
  level_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_level != 2'd3);

  // R4
  locked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!opt_unlocked && !opt_busy) |=> !opt_busy);

  // R5
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(opt_busy) |-> upd_done);

  // R5
  hold_during_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opt_busy |=> (!opt_busy || $stable(rdp_byte)));

  // R6
  erase_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mass_erase_act |-> opt_busy);

  // R8
  refuse_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrp_err |-> !opt_busy);

  // R8
  perm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_level == 2'd2) |=> (prot_level == 2'd2));

  // R10
  mode_off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_mode |-> (sect_rdprot == '0));

endmodule

bind opt_level_mgr opt_level_mgr_chk #(.NSECT(NSECT)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .opt_unlocked   (opt_unlocked),
  .opt_busy       (opt_busy),
  .mass_erase_act (mass_erase_act),
  .upd_done       (upd_done),
  .wrp_err        (wrp_err),
  .prot_level     (prot_level),
  .rdp_byte       (rdp_byte),
  .prot_mode      (prot_mode),
  .sect_rdprot    (sect_rdprot)
);

// File: tb/opt_level_mgr_bench.sv
module opt_level_mgr_bench;

  localparam int NSECT = 12;
  localparam int SECW  = 4;
  localparam int MC    = 3;
  localparam int EC    = 2;
  localparam int PC    = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             key_we;
  logic [31:0]      key_wdata;
  logic             relock;
  logic             start;
  logic [7:0]       req_rdp;
  logic [NSECT-1:0] req_mask;
  logic             req_mode;
  logic             rd_req;
  logic             rd_dport;
  logic [SECW-1:0]  rd_sector;
  logic             opt_unlocked, opt_busy, mass_erase_act, upd_done;
  logic             wrp_err, rd_err, prot_mode;
  logic [1:0]       prot_level;
  logic [7:0]       rdp_byte;
  logic [NSECT-1:0] sect_mask, sect_rdprot;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  opt_level_mgr #(.NSECT(NSECT), .MASS_CYC(MC), .OBER_CYC(EC), .OBPG_CYC(PC)) u_opt_level_mgr (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_wdata(key_wdata), .relock(relock),
    .start(start), .req_rdp(req_rdp), .req_mask(req_mask), .req_mode(req_mode),
    .rd_req(rd_req), .rd_dport(rd_dport), .rd_sector(rd_sector),
    .opt_unlocked(opt_unlocked), .opt_busy(opt_busy), .mass_erase_act(mass_erase_act),
    .upd_done(upd_done), .wrp_err(wrp_err), .rd_err(rd_err), .prot_level(prot_level),
    .rdp_byte(rdp_byte), .sect_mask(sect_mask), .prot_mode(prot_mode),
    .sect_rdprot(sect_rdprot)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int lvl(input logic [7:0] b);
    if (b == 8'hAA) return 0;
    if (b == 8'hCC) return 2;
    return 1;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; key_we = 0; key_wdata = '0; relock = 0; start = 0;
    req_rdp = '0; req_mask = '0; req_mode = 0; rd_req = 0; rd_dport = 0; rd_sector = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_key(input logic [31:0] k);
    key_we = 1; key_wdata = k;
    @(negedge clk);
    key_we = 0;
  endtask

  task automatic unlock();
    send_key(32'h0819_2A3B);
    send_key(32'h4C5D_6E7F);
  endtask

  task automatic run_update(input logic [7:0] r, input logic [NSECT-1:0] m, input logic md,
                            output int nbusy, output int nmass, output logic werr,
                            output logic dn);
    start = 1; req_rdp = r; req_mask = m; req_mode = md;
    @(negedge clk);
    start = 0;
    werr = wrp_err; nbusy = 0; nmass = 0;
    while (opt_busy && nbusy < 100) begin
      nbusy++;
      if (mass_erase_act) nmass++;
      @(negedge clk);
    end
    dn = upd_done;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int nb, nm;
    logic we, dn;

    // R1 reset state
    do_reset();
    check("R1 rdp", rdp_byte, 8'hAA);
    check("R1 mask", sect_mask, 12'hFFF);
    check("R1 mode", prot_mode, 0);
    check("R1 lock", opt_unlocked, 0);
    check("R1 outs", {opt_busy, mass_erase_act, upd_done, wrp_err, rd_err}, 0);
    check("R3 reset level", prot_level, 0);

    // R4 start while locked
    run_update(8'hCC, 12'h000, 1'b1, nb, nm, we, dn);
    check("R4 locked busy", nb, 0);
    check("R4 locked rdp", rdp_byte, 8'hAA);

    // R2 wrong first key, then correct pair
    send_key(32'h1234_5678);
    unlock();
    check("R2 dead after bad key1", opt_unlocked, 0);
    do_reset();
    send_key(32'h0819_2A3B);
    send_key(32'h0819_2A3B);
    unlock();
    check("R2 dead after bad key2", opt_unlocked, 0);
    do_reset();
    unlock();
    check("R2 unlocked", opt_unlocked, 1);
    relock = 1; @(negedge clk); relock = 0;
    check("R2 relock", opt_unlocked, 0);
    run_update(8'h55, 12'hFFF, 1'b0, nb, nm, we, dn);
    check("R4 relocked start", {nb[7:0], rdp_byte}, {8'd0, 8'hAA});
    unlock();
    check("R2 reopen after relock", opt_unlocked, 1);
    send_key(32'h0819_2A3B);
    check("R2 key while open locks", opt_unlocked, 0);

    // R4 start while busy
    do_reset();
    unlock();
    start = 1; req_rdp = 8'h55; req_mask = 12'hFFF; req_mode = 0;
    @(negedge clk);
    req_rdp = 8'hCC;
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    check("R4 busy start ignored", rdp_byte, 8'h55);

    // R3 R7 decode sweep over every byte value
    for (int v = 0; v < 256; v++) begin
      do_reset();
      unlock();
      run_update(v[7:0], 12'hFFF, 1'b0, nb, nm, we, dn);
      check("R3 level", prot_level, lvl(v[7:0]));
      check("R7 no erase on raise", {nm[7:0], 7'd0, we}, 16'd0);
      check("R5 busy len", nb, EC + PC);
    end

    // R5 R6 R7 R8 R9 transition sweep
    for (int oi = 0; oi < 3; oi++)
      for (int ni = 0; ni < 4; ni++)
        for (int om = 0; om < 2; om++)
          for (int nmd = 0; nmd < 2; nmd++)
            for (int dr = 0; dr < 2; dr++) begin
              logic [7:0] orp, nrp;
              logic [NSECT-1:0] omask, nmask;
              logic exp_ref, exp_er, opn;
              int ol, nl;
              orp = (oi == 0) ? 8'hAA : (oi == 1) ? 8'h55 : 8'hCC;
              nrp = (ni == 0) ? 8'hAA : (ni == 1) ? 8'h12 : (ni == 2) ? 8'hCC : 8'h55;
              omask = 12'hA5C;
              nmask = dr ? (omask & ~12'h004) : (omask | 12'h003);
              do_reset();
              unlock();
              run_update(orp, omask, om[0], nb, nm, we, dn);
              ol = lvl(orp); nl = lvl(nrp);
              opn = (ol == 1) && (nl == 0);
              exp_ref = ((ol == 2) && (nl != 2)) ||
                        (((om == 1) && (nmd == 0)) || ((om == 1) && (nmd == 1) && (dr == 1))) && !opn;
              exp_er = !exp_ref && opn;
              run_update(nrp, nmask, nmd[0], nb, nm, we, dn);
              if (exp_ref) begin
                // R8 R9 refused request
                check("R8 R9 wrp_err", we, 1);
                check("R8 R9 no busy", nb, 0);
                check("R8 R9 unchanged", {prot_mode, sect_mask, rdp_byte}, {om[0], omask, orp});
              end else begin
                check("R5 accepted no err", we, 0);
                check("R5 busy cycles", nb, EC + PC + (exp_er ? MC : 0));
                check("R5 done pulse", dn, 1);
                check("R5 committed", {prot_mode, sect_mask, rdp_byte}, {nmd[0], nmask, nrp});
                check("R6 R7 erase cycles", nm, exp_er ? MC : 0);
              end
              check("R10 rdprot", sect_rdprot, prot_mode ? sect_mask : 12'h000);
            end

    // R7 no net change
    do_reset();
    unlock();
    run_update(8'h55, 12'h0F0, 1'b1, nb, nm, we, dn);
    run_update(8'h55, 12'h0F0, 1'b1, nb, nm, we, dn);
    check("R7 same request", {nb[7:0], nm[7:0], 7'd0, we}, {8'(EC + PC), 8'd0, 8'd0});

    // R11 read error sweep, mode off then on
    for (int ph = 0; ph < 2; ph++) begin
      do_reset();
      unlock();
      if (ph == 1) run_update(8'hAA, 12'hA5C, 1'b1, nb, nm, we, dn);
      check("R10 rdprot phase", sect_rdprot, (ph == 1) ? 12'hA5C : 12'h000);
      for (int s = 0; s < 16; s++)
        for (int d = 0; d < 2; d++) begin
          logic [15:0] pm;
          pm = (ph == 1) ? 16'h0A5C : 16'h0000;
          rd_req = 1; rd_dport = d[0]; rd_sector = s[3:0];
          @(negedge clk);
          rd_req = 0;
          check("R11 rd_err", rd_err, (d == 1) && pm[s]);
        end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule